// File: doc/BRIEF.md
# Per-Channel Interrupt Coalescing Controller

This block sits beside one DMA channel's sequencer and turns a stream of descriptor-completion events into a much smaller number of interrupt requests. Each completion arrives as a one-cycle strobe with an accompanying flag saying whether the descriptor asked for an interrupt. Unflagged completions are dropped. The first flagged completion after an acknowledge opens a coalescing window. Later flagged completions are absorbed into that window. When the window ends, a single level interrupt request is raised and held until software acknowledges it.

The window length is programmed in microseconds through a 14-bit delay register, so the longest window is 16383 us. Writes above that limit clamp to it, and the limit itself is reported on a read-only port so software can discover it. A prescaler divides the system clock by the clock frequency in MHz to make the microsecond tick. It restarts at the opening of each window, so the window lasts exactly delay x CLK_MHZ cycles. A delay of zero disables coalescing: the request follows a flagged completion on the next cycle.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0 and the delay read back on `cfg_delay` is 0.
- R2: `max_period` always reads 16383, the largest window in microseconds.
- R3: A write (`cfg_we`=1) stores `cfg_wdata` into the delay when the value is at most 16383, and stores 16383 when the value is larger. The result is visible on `cfg_delay` the cycle after the write.
- R4: A completion with `cmp_irq_en`=0 never raises `irq_req` and never opens a window.
- R5: With a delay of 0, a flagged completion (`cmp_valid`=1 and `cmp_irq_en`=1) sampled at a clock edge while no window is open and `irq_req` is low raises `irq_req` right after that edge.
- R6: With a delay D>0, `irq_req` rises exactly D x CLK_MHZ clock edges after the edge that sampled the window-opening flagged completion, and stays low before that.
- R7: Flagged completions that arrive while a window is open or while `irq_req` is high neither restart the window nor cause a second request. Once acknowledged, `irq_req` stays low until a new flagged completion opens a new window.
- R8: `irq_req` stays high until `irq_ack` is sampled high. It is then low after that edge, unless R9 applies with a delay of 0.
- R9: A flagged completion sampled in the same cycle as the acknowledge opens a new window that starts at that edge.
- R10: The window length is fixed when the window opens. A delay write during an open window affects only later windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Delay register write strobe |
| cfg_wdata | input | WDATA_W | Delay value to write, in microseconds |
| cfg_delay | output | 14 | Current delay register value |
| max_period | output | 14 | Largest supported window in microseconds (16383) |
| cmp_valid | input | 1 | One-cycle descriptor completion strobe |
| cmp_irq_en | input | 1 | Completion requested an interrupt |
| irq_ack | input | 1 | Software acknowledge pulse |
| irq_req | output | 1 | Level interrupt request |

## Verification
The bench drives bursts of flagged completions inside one window, at irregular points, and checks that exactly one request appears on the predicted edge. This shows whether the window is merged or restarted by later events. Streams of unflagged completions with a delay of 0 show whether the flag gates the request at all. A delay of 0 shows whether the block bypasses coalescing. An acknowledge that coincides with a completion shows whether the new window starts on the acknowledge edge. A delay rewrite inside an open window shows whether the length is latched when the window opens or read live from the register.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    localparam int DELAY_W = 14;
    localparam int MAX_US  = 16383;

    typedef enum logic [1:0] {
        CO_IDLE = 2'd0,
        CO_WAIT = 2'd1,
        CO_FIRE = 2'd2
    } coal_state_e;

    typedef struct packed {
        coal_state_e          state;
        logic [DELAY_W-1:0]   remain;
    } coal_ctx_t;

    function automatic int cnt_width(input int div);
        return (div > 1) ? $clog2(div) : 1;
    endfunction

endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = irq_coal_pkg::cnt_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/coal_delay_reg.sv
module coal_delay_reg
    import irq_coal_pkg::*;
#(
    parameter int WDATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [WDATA_W-1:0] wdata,
    output logic [DELAY_W-1:0] delay
);
    localparam logic [WDATA_W-1:0] CAP_W = WDATA_W'(MAX_US);

    logic [DELAY_W-1:0] clamped;

    always_comb begin
        if (wdata > CAP_W)
            clamped = DELAY_W'(MAX_US);
        else
            clamped = wdata[DELAY_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            delay <= '0;
        else if (we)
            delay <= clamped;
    end
endmodule

// File: rtl/coal_window.sv
module coal_window
    import irq_coal_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flagged,
    input  logic               ack,
    input  logic [DELAY_W-1:0] delay,
    input  logic               tick,
    output logic               restart,
    output logic               busy,
    output logic               irq
);
    coal_ctx_t ctx, ctx_n;
    logic      opening;

    always_comb begin
        opening = flagged && ((ctx.state == CO_IDLE) ||
                              (ctx.state == CO_FIRE && ack));
        ctx_n = ctx;
        if (opening) begin
            ctx_n.remain = delay;
            ctx_n.state  = (delay == '0) ? CO_FIRE : CO_WAIT;
        end else begin
            case (ctx.state)
                CO_WAIT: begin
                    if (tick) begin
                        if (ctx.remain == DELAY_W'(1))
                            ctx_n.state = CO_FIRE;
                        ctx_n.remain = ctx.remain - DELAY_W'(1);
                    end
                end
                CO_FIRE: begin
                    if (ack)
                        ctx_n.state = CO_IDLE;
                end
                default: ctx_n = ctx;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.state  <= CO_IDLE;
            ctx.remain <= '0;
        end else begin
            ctx <= ctx_n;
        end
    end

    assign restart = opening;
    assign busy    = (ctx.state == CO_WAIT);
    assign irq     = (ctx.state == CO_FIRE);
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import irq_coal_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int WDATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [WDATA_W-1:0] cfg_wdata,
    output logic [DELAY_W-1:0] cfg_delay,
    output logic [DELAY_W-1:0] max_period,
    input  logic               cmp_valid,
    input  logic               cmp_irq_en,
    input  logic               irq_ack,
    output logic               irq_req
);
    logic us_tick;
    logic win_restart;
    logic win_busy;
    logic cmp_flagged;

    assign cmp_flagged = cmp_valid & cmp_irq_en;
    assign max_period  = DELAY_W'(MAX_US);

    coal_delay_reg #(.WDATA_W(WDATA_W)) u_dreg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .delay (cfg_delay)
    );

    us_prescaler #(.DIV(CLK_MHZ)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .restart (win_restart),
        .tick    (us_tick)
    );

    coal_window u_win (
        .clk     (clk),
        .rst     (rst),
        .flagged (cmp_flagged),
        .ack     (irq_ack),
        .delay   (cfg_delay),
        .tick    (us_tick),
        .restart (win_restart),
        .busy    (win_busy),
        .irq     (irq_req)
    );
endmodule

module irq_coalesce_chk
    import irq_coal_pkg::*;
#(
    parameter int WDATA_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [WDATA_W-1:0] cfg_wdata,
    input logic [DELAY_W-1:0] cfg_delay,
    input logic               cmp_valid,
    input logic               cmp_irq_en,
    input logic               irq_ack,
    input logic               irq_req,
    input logic               busy
);
    logic flg;
    assign flg = cmp_valid & cmp_irq_en;

    p_write_sat_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata > WDATA_W'(MAX_US)) |=> cfg_delay == DELAY_W'(MAX_US));

    p_write_exact_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata <= WDATA_W'(MAX_US)) |=> cfg_delay == $past(cfg_wdata[DELAY_W-1:0]));

    p_unflagged_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && !busy && !flg) |=> (!irq_req && !busy));

    p_zero_delay_r5: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && !busy && flg && cfg_delay == '0) |=> irq_req);

    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> irq_req);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && !flg) |=> !irq_req);

    p_ack_reopen_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && flg && cfg_delay != '0) |=> (busy && !irq_req));
endmodule

bind irq_coalesce_ctrl irq_coalesce_chk #(.WDATA_W(WDATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_delay  (cfg_delay),
    .cmp_valid  (cmp_valid),
    .cmp_irq_en (cmp_irq_en),
    .irq_ack    (irq_ack),
    .irq_req    (irq_req),
    .busy       (win_busy)
);

// File: tb/irq_coalesce_ctrl_test.sv
module irq_coalesce_ctrl_test;
    localparam int MHZ = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [13:0] cfg_delay;
    logic [13:0] max_period;
    logic        cmp_valid = 1'b0;
    logic        cmp_irq_en = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_coalesce_ctrl #(.CLK_MHZ(MHZ), .WDATA_W(16)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_delay(cfg_delay), .max_period(max_period),
        .cmp_valid(cmp_valid), .cmp_irq_en(cmp_irq_en),
        .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_delay(input int v);
        cfg_we = 1'b1; cfg_wdata = v[15:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_cmp(input bit en);
        cmp_valid = 1'b1; cmp_irq_en = en;
        @(negedge clk);
        cmp_valid = 1'b0; cmp_irq_en = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", int'(irq_req), 0);
        chk("R1 delay after reset", int'(cfg_delay), 0);
        chk("R2 max period", int'(max_period), 16383);
    endtask

    task automatic t_saturate();
        write_delay(20000);  chk("R3 write 20000", int'(cfg_delay), 16383);
        write_delay(5);      chk("R3 write 5", int'(cfg_delay), 5);
        write_delay(16384);  chk("R3 write 16384", int'(cfg_delay), 16383);
        write_delay(16383);  chk("R3 write 16383", int'(cfg_delay), 16383);
        write_delay(65535);  chk("R3 write 65535", int'(cfg_delay), 16383);
        chk("R2 max period stable", int'(max_period), 16383);
    endtask

    task automatic t_unflagged();
        int seen = 0;
        write_delay(0);
        for (int k = 0; k < 6; k++) begin
            pulse_cmp(1'b0);
            if (irq_req) seen++;
        end
        repeat (8) begin
            @(negedge clk);
            if (irq_req) seen++;
        end
        chk("R4 unflagged completions raise nothing", seen, 0);
    endtask

    task automatic t_zero_delay();
        write_delay(0);
        chk("R5 low before completion", int'(irq_req), 0);
        pulse_cmp(1'b1);
        chk("R5 high right after completion edge", int'(irq_req), 1);
        do_ack();
        chk("R8 ack clears", int'(irq_req), 0);
    endtask

    task automatic t_window();
        int len = 4 * MHZ;
        int extra = 0;
        write_delay(4);
        pulse_cmp(1'b1);
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (i == len - 1) chk("R6 still low one edge early", int'(irq_req), 0);
            if (i < len - 1 && irq_req) extra++;
            cmp_valid  = (i == 3 || i == 8);
            cmp_irq_en = (i == 3 || i == 8);
        end
        chk("R6 high at D*CLK_MHZ edges", int'(irq_req), 1);
        chk("R7 no early request from later completions", extra, 0);
        pulse_cmp(1'b1);
        repeat (20) @(negedge clk);
        chk("R8 held without ack", int'(irq_req), 1);
        do_ack();
        chk("R8 low after ack", int'(irq_req), 0);
        extra = 0;
        repeat (3 * len) begin
            @(negedge clk);
            if (irq_req) extra++;
        end
        chk("R7 single request per window", extra, 0);
    endtask

    task automatic t_ack_restart();
        int len = 2 * MHZ;
        write_delay(2);
        pulse_cmp(1'b1);
        repeat (len) @(negedge clk);
        chk("R6 delay 2 request", int'(irq_req), 1);
        irq_ack = 1'b1; cmp_valid = 1'b1; cmp_irq_en = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0; cmp_valid = 1'b0; cmp_irq_en = 1'b0;
        chk("R9 ack edge drops request", int'(irq_req), 0);
        repeat (len - 1) @(negedge clk);
        chk("R9 new window not yet done", int'(irq_req), 0);
        @(negedge clk);
        chk("R9 new window fires from ack edge", int'(irq_req), 1);
        do_ack();
    endtask

    task automatic t_delay_change();
        int len = 5 * MHZ;
        write_delay(5);
        pulse_cmp(1'b1);
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (i == len - 1) chk("R10 old length kept (low)", int'(irq_req), 0);
            cfg_we    = (i == 2);
            cfg_wdata = 16'd1;
        end
        cfg_we = 1'b0;
        chk("R10 old length kept (high)", int'(irq_req), 1);
        chk("R10 new delay stored", int'(cfg_delay), 1);
        do_ack();
        pulse_cmp(1'b1);
        repeat (MHZ - 1) @(negedge clk);
        chk("R10 next window low", int'(irq_req), 0);
        @(negedge clk);
        chk("R10 next window uses new delay", int'(irq_req), 1);
        do_ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_saturate();
        t_unflagged();
        t_zero_delay();
        t_window();
        t_ack_restart();
        t_delay_change();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R6: run hung, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule